// File: doc/BRIEF.md
# Cartridge ROM-Overlay GPIO Port

This block is a four-pin general-purpose I/O port that lives inside a cartridge ROM device. It shares the cartridge's address and data bus with the ROM contents. Three halfword locations near the bottom of ROM space act as the port's pin-value, pin-direction and readback-control registers. A write to one of those locations always reaches the port. A read from one of them returns either the ROM word or the port state, depending on one readback-enable bit. Every other address is a plain ROM location.

Software uses the pins to drive an external serial peripheral by toggling them one at a time: a chip select, a serial clock and a bidirectional data line, for example a real-time clock. No serial engine is involved. The ROM array is outside the block and is presented as an input word. Pad inputs and the peripheral's interrupt line are asynchronous to the bus clock, so both pass through two-stage synchronizers.

Top module: `cart_gpio_overlay`

## Requirements
- R1: After a synchronous active-low reset, the pin-value, direction and readback-enable registers are 0. `pad_oe` and `pad_out` are therefore 0, `irq_out` is 0, and every address returns `rom_rdata` on `bus_rdata`.
- R2: Registers are decoded at byte offsets 0xC4 (pin values), 0xC6 (direction) and 0xC8 (control). Address bit 0 is ignored, and all other address bits must match exactly. Every other address returns `rom_rdata` unchanged.
- R3: A write at one of the three offsets updates its register one clock later, whether readback is enabled or not.
- R4: Control bit 0 is the readback enable. While it is 1, reads at the three offsets return register data. While it is 0, they return `rom_rdata`. The control register reads back as its bit 0 in bit 0.
- R5: A direction bit of 1 sets `pad_oe` for that pin and drives `pad_out` from the pin-value register. A direction bit of 0 clears `pad_oe`.
- R6: A pin-value read returns the stored value for output pins and the synchronized pad level for input pins. A pad change becomes visible after the second rising clock edge and not after the first.
- R7: Only bits 3:0 of the pin-value and direction registers and bit 0 of the control register are stored. All other read bits of the three registers are 0.
- R8: Writes to any address other than the three offsets change no register state. This includes addresses that differ from an offset only in an upper bit.
- R9: `periph_irq` reaches `irq_out` through a two-stage synchronizer, so `irq_out` follows it two rising edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W (24) | Cartridge byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 16 | Write data halfword |
| rom_rdata | input | 16 | Word read from the ROM array at `bus_addr` |
| bus_rdata | output | 16 | Read data returned to the bus (combinational) |
| pad_in | input | PIN_N (4) | Sampled pad levels, asynchronous |
| pad_out | output | PIN_N (4) | Pad output values |
| pad_oe | output | PIN_N (4) | Pad output enables, 1 = driven |
| periph_irq | input | 1 | Interrupt line from the serial peripheral, asynchronous |
| irq_out | output | 1 | Synchronized interrupt |

## Verification
The assertions assume that `bus_addr`, `bus_wdata` and `bus_wr` are stable around each rising edge, and that a write is a single-cycle strobe sampled at that edge. They also assume that `pad_in` and `periph_irq` may change at any time, and that only their synchronized values are checked. The stimulus changes every input on the falling clock edge and holds it through the following rising edge, so no sample is ambiguous. The interrupt-delay check is gated by a counter of cycles since reset, so it never compares against values from before reset was released.

// File: rtl/cgpio_pkg.sv
// Shared definitions for the cartridge overlay GPIO port.
// Assumes a 16-bit halfword data bus and byte addressing.
package cgpio_pkg;

    localparam int BUS_W = 16;

    // Default byte offsets of the overlay registers (behaviour depends on them)
    localparam logic [31:0] OFF_PINS = 32'h0000_00C4;
    localparam logic [31:0] OFF_DIR  = 32'h0000_00C6;
    localparam logic [31:0] OFF_CTL  = 32'h0000_00C8;

    // Register selected by the current address
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_PINS = 2'd1,
        SEL_DIR  = 2'd2,
        SEL_CTL  = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/cgpio_decode.sv
// Address decoder: compares the halfword address against the three
// register offsets. Assumes bit 0 of the byte address is don't-care.
module cgpio_decode
    import cgpio_pkg::*;
#(
    parameter int          ADDR_W   = 24,
    parameter logic [31:0] A_PINS   = OFF_PINS,
    parameter logic [31:0] A_DIR    = OFF_DIR,
    parameter logic [31:0] A_CTL    = OFF_CTL
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    localparam int HW_W = ADDR_W - 1;
    localparam logic [HW_W-1:0] HW_PINS = A_PINS[HW_W:1];
    localparam logic [HW_W-1:0] HW_DIR  = A_DIR[HW_W:1];
    localparam logic [HW_W-1:0] HW_CTL  = A_CTL[HW_W:1];

    logic [HW_W-1:0] hw_addr;
    assign hw_addr = addr[ADDR_W-1:1];

    // Full-width halfword compare against each register offset
    always_comb begin
        if (hw_addr == HW_PINS)      sel = SEL_PINS;
        else if (hw_addr == HW_DIR)  sel = SEL_DIR;
        else if (hw_addr == HW_CTL)  sel = SEL_CTL;
        else                         sel = SEL_NONE;
    end
endmodule

// File: rtl/cgpio_sync.sv
// Multi-stage synchronizer for asynchronous inputs. Assumes STAGES >= 2;
// all stages clear on reset.
module cgpio_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    // First stage captures the raw asynchronous input
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= din;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        // Each further stage re-times the previous one
        always_ff @(posedge clk) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/cgpio_regs.sv
// Pin-value, direction and readback-enable registers. Writes are
// accepted for the selected register whenever the strobe is high,
// independent of the readback enable.
module cgpio_regs
    import cgpio_pkg::*;
#(
    parameter int PIN_N = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  reg_sel_e         sel,
    input  logic [PIN_N-1:0] wpins,
    input  logic             wctl,
    output logic [PIN_N-1:0] pins_q,
    output logic [PIN_N-1:0] dir_q,
    output logic             ctl_q
);
    // Pin-value register
    always_ff @(posedge clk) begin
        if (!rst_n)                        pins_q <= '0;
        else if (wr && sel == SEL_PINS)    pins_q <= wpins;
    end

    // Direction register
    always_ff @(posedge clk) begin
        if (!rst_n)                        dir_q <= '0;
        else if (wr && sel == SEL_DIR)     dir_q <= wpins;
    end

    // Readback-enable bit
    always_ff @(posedge clk) begin
        if (!rst_n)                        ctl_q <= 1'b0;
        else if (wr && sel == SEL_CTL)     ctl_q <= wctl;
    end
endmodule

// File: rtl/cart_gpio_overlay.sv
// Top of the cartridge overlay GPIO port. Decodes the three register
// offsets, holds the port registers, drives the pad controls and muxes
// register data over ROM data when readback is enabled. Assumes the
// ROM word for bus_addr is presented combinationally on rom_rdata.
module cart_gpio_overlay
    import cgpio_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int PIN_N      = 4,
    parameter int SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic [BUS_W-1:0]  rom_rdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [PIN_N-1:0]  pad_in,
    output logic [PIN_N-1:0]  pad_out,
    output logic [PIN_N-1:0]  pad_oe,
    input  logic              periph_irq,
    output logic              irq_out
);
    localparam int PAD_HI = BUS_W - PIN_N;

    reg_sel_e         sel;
    logic [PIN_N-1:0] pins_q;
    logic [PIN_N-1:0] dir_q;
    logic             ctl_en;
    logic [PIN_N-1:0] pad_sync;
    logic [PIN_N-1:0] pins_view;
    logic [BUS_W-1:0] reg_rdata;

    cgpio_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr (bus_addr),
        .sel  (sel)
    );

    cgpio_regs #(.PIN_N(PIN_N)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (bus_wr),
        .sel    (sel),
        .wpins  (bus_wdata[PIN_N-1:0]),
        .wctl   (bus_wdata[0]),
        .pins_q (pins_q),
        .dir_q  (dir_q),
        .ctl_q  (ctl_en)
    );

    cgpio_sync #(.WIDTH(PIN_N), .STAGES(SYNC_DEPTH)) u_pad_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pad_in),
        .dout  (pad_sync)
    );

    cgpio_sync #(.WIDTH(1), .STAGES(SYNC_DEPTH)) u_irq_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (periph_irq),
        .dout  (irq_out)
    );

    assign pad_out = pins_q;
    assign pad_oe  = dir_q;

    for (genvar i = 0; i < PIN_N; i++) begin : g_view
        // Output pins read the driven value, input pins the synchronized pad
        assign pins_view[i] = dir_q[i] ? pins_q[i] : pad_sync[i];
    end

    // Register readback selected by the decoded address
    always_comb begin
        case (sel)
            SEL_PINS: reg_rdata = {{PAD_HI{1'b0}}, pins_view};
            SEL_DIR:  reg_rdata = {{PAD_HI{1'b0}}, dir_q};
            SEL_CTL:  reg_rdata = {{(BUS_W-1){1'b0}}, ctl_en};
            default:  reg_rdata = rom_rdata;
        endcase
    end

    // Overlay mux: register data only when readback is enabled
    assign bus_rdata = ctl_en ? reg_rdata : rom_rdata;
endmodule

// File: rtl/cgpio_checker.sv
// Assertion checker bound to cart_gpio_overlay. Assumes inputs are
// stable around each rising edge.
module cgpio_checker
    import cgpio_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int PIN_N  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [BUS_W-1:0]  bus_wdata,
    input logic [BUS_W-1:0]  rom_rdata,
    input logic [BUS_W-1:0]  bus_rdata,
    input logic [PIN_N-1:0]  pad_out,
    input logic [PIN_N-1:0]  pad_oe,
    input logic              periph_irq,
    input logic              irq_out,
    input logic              ctl_en
);
    logic hit_pins, hit_dir, hit_ctl, hit_any;
    assign hit_pins = (bus_addr[ADDR_W-1:1] == OFF_PINS[ADDR_W-1:1]);
    assign hit_dir  = (bus_addr[ADDR_W-1:1] == OFF_DIR[ADDR_W-1:1]);
    assign hit_ctl  = (bus_addr[ADDR_W-1:1] == OFF_CTL[ADDR_W-1:1]);
    assign hit_any  = hit_pins | hit_dir | hit_ctl;

    // Cycles since reset release, saturating at 2
    logic [1:0] live_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n)               live_cnt <= 2'd0;
        else if (live_cnt != 2'd2) live_cnt <= live_cnt + 2'd1;
    end

    AST_ROM_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_any |-> bus_rdata == rom_rdata);  // R2
    AST_ROM_WHEN_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_en |-> bus_rdata == rom_rdata);  // R4
    AST_CTL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && hit_ctl |=> ctl_en == $past(bus_wdata[0]));  // R3
    AST_DIR_TO_OE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && hit_dir |=> pad_oe == $past(bus_wdata[PIN_N-1:0]));  // R5
    AST_PINS_TO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && hit_pins |=> pad_out == $past(bus_wdata[PIN_N-1:0]));  // R3
    AST_OTHER_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && !hit_any |=> $stable(pad_oe) && $stable(pad_out) && $stable(ctl_en));  // R8
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_en && hit_any |-> bus_rdata[BUS_W-1:PIN_N] == '0);  // R7
    AST_IRQ_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        live_cnt == 2'd2 |-> irq_out == $past(periph_irq, 2));  // R9
endmodule

bind cart_gpio_overlay cgpio_checker #(.ADDR_W(ADDR_W), .PIN_N(PIN_N)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .rom_rdata  (rom_rdata),
    .bus_rdata  (bus_rdata),
    .pad_out    (pad_out),
    .pad_oe     (pad_oe),
    .periph_irq (periph_irq),
    .irq_out    (irq_out),
    .ctl_en     (ctl_en)
);

// File: tb/cart_gpio_overlay_bench.sv
module cart_gpio_overlay_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] rom_rdata = '0;
    logic [15:0] bus_rdata;
    logic [3:0]  pad_in = 4'b1010;
    logic [3:0]  pad_out, pad_oe;
    logic        periph_irq = 1'b0;
    logic        irq_out;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    cart_gpio_overlay u_cart_gpio_overlay (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .rom_rdata(rom_rdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .periph_irq(periph_irq), .irq_out(irq_out)
    );

    typedef struct packed {
        logic        wr;
        logic [23:0] addr;
        logic [15:0] wd;
        logic [15:0] rom;
        logic [15:0] exp;
    } vec_t;

    // pad_in is 1010 throughout the table
    localparam int NV = 20;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 24'h0000C4, 16'h0000, 16'hA5C3, 16'hA5C3},  // R1 hidden at reset
        '{1'b1, 24'h0000C6, 16'hFFF5, 16'h0000, 16'h0000},  // R7 dir=0101
        '{1'b1, 24'h0000C4, 16'hFF03, 16'h0000, 16'h0000},  // R3 pins=0011
        '{1'b0, 24'h0000C6, 16'h0000, 16'h1234, 16'h1234},  // R4 still ROM
        '{1'b0, 24'h0000C8, 16'h0000, 16'h4321, 16'h4321},  // R4 still ROM
        '{1'b1, 24'h0000C8, 16'h0001, 16'h0000, 16'h0000},  // R4 enable
        '{1'b0, 24'h0000C6, 16'h0000, 16'h1234, 16'h0005},  // R7 upper zero
        '{1'b0, 24'h0000C4, 16'h0000, 16'h1234, 16'h000B},  // R6 mixed dir
        '{1'b0, 24'h0000C8, 16'h0000, 16'h1234, 16'h0001},  // R4 ctl readback
        '{1'b0, 24'h0000CA, 16'h0000, 16'h7777, 16'h7777},  // R2 above
        '{1'b0, 24'h0000C2, 16'h0000, 16'h6666, 16'h6666},  // R2 below
        '{1'b0, 24'h0000C5, 16'h0000, 16'h1234, 16'h000B},  // R2 bit0 ignored
        '{1'b1, 24'h0000CA, 16'hFFFF, 16'h0000, 16'h0000},  // R8 stray write
        '{1'b1, 24'h0100C6, 16'h0000, 16'h0000, 16'h0000},  // R8 alias write
        '{1'b0, 24'h0000C6, 16'h0000, 16'h9999, 16'h0005},  // R8 dir kept
        '{1'b0, 24'h0100C4, 16'h0000, 16'h5A5A, 16'h5A5A},  // R2 upper bit differs
        '{1'b1, 24'h0000C8, 16'hFFFE, 16'h0000, 16'h0000},  // R4 disable
        '{1'b0, 24'h0000C8, 16'h0000, 16'h2468, 16'h2468},  // R4 hidden again
        '{1'b0, 24'h0000C4, 16'h0000, 16'h1357, 16'h1357},  // R4 hidden pins
        '{1'b0, 24'h000000, 16'h0000, 16'hBEEF, 16'hBEEF}   // R2 ROM base
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [23:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [23:0] a, input logic [15:0] rom,
                            input logic [15:0] exp, input string req);
        @(negedge clk);
        bus_addr = a; rom_rdata = rom; bus_wr = 1'b0;
        #1;
        check(req, bus_rdata, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 pad_oe", {12'h0, pad_oe}, 16'h0);
        check("R1 pad_out", {12'h0, pad_out}, 16'h0);
        check("R1 irq_out", {15'h0, irq_out}, 16'h0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        for (int k = 0; k < NV; k++) begin
            if (VEC[k].wr) bus_write(VEC[k].addr, VEC[k].wd);
            else bus_read(VEC[k].addr, VEC[k].rom, VEC[k].exp, $sformatf("table row %0d", k));
        end

        // R3 R5: writes while hidden still reach pads
        bus_write(24'h0000C6, 16'h0009);
        #1 check("R3 R5 pad_oe", {12'h0, pad_oe}, 16'h0009);
        bus_write(24'h0000C4, 16'h0006);
        #1 check("R3 pad_out", {12'h0, pad_out}, 16'h0006);

        // R6 synchronizer depth on an input pin (dir=0000)
        bus_write(24'h0000C6, 16'h0000);
        bus_write(24'h0000C8, 16'h0001);
        pad_in = 4'b0000;
        repeat (3) @(negedge clk);
        bus_addr = 24'h0000C4;
        pad_in = 4'b0101;
        @(negedge clk); #1;
        check("R6 after one edge", bus_rdata, 16'h0000);
        @(negedge clk); #1;
        check("R6 after two edges", bus_rdata, 16'h0005);

        // R9 interrupt synchronizer
        periph_irq = 1'b1;
        @(negedge clk); #1;
        check("R9 after one edge", {15'h0, irq_out}, 16'h0);
        @(negedge clk); #1;
        check("R9 after two edges", {15'h0, irq_out}, 16'h1);

        // R1 reset in mid-run clears state
        bus_write(24'h0000C6, 16'h000F);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        periph_irq = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 reset pad_oe", {12'h0, pad_oe}, 16'h0);
        check("R1 reset irq", {15'h0, irq_out}, 16'h0);
        rst_n = 1'b1;
        bus_read(24'h0000C8, 16'hC0DE, 16'hC0DE, "R1 ctl cleared");

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule